// File: doc/BRIEF.md
# Ping-pong audio frame buffer

This block sits between a sample-rate audio stream and a frame-rate processing engine. The stream side delivers interleaved stereo samples one at a time. The engine works on whole frames. Input and output each have two banks of storage. The stream fills one input bank while the engine reads the other. The stream also drains one output bank while the engine writes the other. When a bank reaches its end, the side it belongs to switches to the other bank and raises a flag. The input side raises a receive-full flag, and the output side raises a transmit-empty flag. The block also reports which bank the engine may now use.

The engine sees a single frame address. That address selects the free input bank for reading and the free output bank for writing, so the engine never has to track ping and pong itself. The engine may start a frame only when both flags are set. It pulses a done strobe at the end of the frame, which drops both flags. If an input bank completes while the previous full frame was never consumed, an overrun flag is raised and the older frame is overwritten. When input and output are stepped by the same strobe, a sample reaches the output exactly two frames after it entered.

Top module: `audio_pingpong_buf`

## Requirements
- R1: After reset: rx_full=0, tx_empty=1, frame_ready=0, overrun=0, rx_bank=1 and tx_bank=1. Bank code 0 is the ping bank and 1 is the pong bank. Filling and draining both start in the ping bank at address 0.
- R2: Each cycle with in_valid high stores in_data at the next address of the bank being filled. The cycle that stores address FRAME_LEN-1 moves filling to the other bank. In the following cycle rx_bank names the bank just filled and rx_full is 1.
- R3: Interleaving: even frame addresses hold left samples and odd addresses hold right samples. in_is_right shows bit 0 of the next fill address, and out_is_right shows bit 0 of the current drain address.
- R4: out_data shows the entry at the current address of the bank being drained. Each cycle with out_ready high moves to the next address. The cycle that consumes address FRAME_LEN-1 moves draining to the other bank. In the following cycle tx_bank names the bank just drained and tx_empty is 1.
- R5: proc_rd_data is, in the same cycle, the entry at proc_addr of the input bank named by rx_bank. While tx_empty is 1, proc_wr_en writes proc_wr_data to proc_addr of the output bank named by tx_bank. While tx_empty is 0, a write has no effect on any stored sample.
- R6: frame_ready is 1 exactly when rx_full and tx_empty are both 1.
- R7: A proc_done pulse makes rx_full and tx_empty 0 in the next cycle. If a bank switch on one side lands in the same cycle, the set on that side wins.
- R8: If the input bank switches while rx_full is still 1 and proc_done is low, overrun becomes 1 in the next cycle. rx_bank then names the newest frame, and the older frame is lost. overrun stays 1 until a proc_done pulse.
- R9: When in_valid and out_ready are the same strobe and the engine turns every ready frame into the output bank it is offered, input sample k reaches out_data at output strobe k + 2*FRAME_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream input sample strobe |
| in_data | input | SAMPLE_W | Stream input sample |
| in_is_right | output | 1 | Next input sample is the right channel |
| out_ready | input | 1 | Stream output takes the presented sample |
| out_data | output | SAMPLE_W | Stream output sample presented |
| out_is_right | output | 1 | Presented output sample is the right channel |
| proc_addr | input | log2(FRAME_LEN) | Engine frame address |
| proc_rd_data | output | SAMPLE_W | Entry of the free input bank at proc_addr |
| proc_wr_en | input | 1 | Engine write into the free output bank |
| proc_wr_data | input | SAMPLE_W | Engine write data |
| proc_done | input | 1 | Engine finished the current frame |
| frame_ready | output | 1 | Both banks available for a frame |
| rx_full | output | 1 | An input frame is waiting |
| tx_empty | output | 1 | An output bank is waiting to be written |
| rx_bank | output | 1 | Input bank offered to the engine (0 ping, 1 pong) |
| tx_bank | output | 1 | Output bank offered to the engine (0 ping, 1 pong) |
| overrun | output | 1 | An unconsumed input frame was overwritten |

## Verification
A wrong bank selection or pointer shows up in proc_rd_data in the same cycle the engine reads it. A bad drain pointer shows up on out_data on the very next output strobe. A wrap placed at the wrong count moves the rise of rx_full or tx_empty away from strobe FRAME_LEN, and the bench compares those flags every clock. A write-gating or delay fault only appears two frames later, when the affected output bank drains. The latency comparison therefore covers the full output window that the engine wrote.

// File: rtl/afb_pkg.sv
// Shared types for the ping-pong audio frame buffer.
// Assumes: exactly two banks per direction.
package afb_pkg;
    typedef enum logic {
        BANK_PING = 1'b0,
        BANK_PONG = 1'b1
    } bank_e;
endpackage

// File: rtl/afb_bank_pair.sv
// Two equal sample banks with one write port and one asynchronous read port.
// The write and the read each select a bank.
// Assumes: the caller keeps the write bank and the read bank apart, or accepts write-through.
module afb_bank_pair
    import afb_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  bank_e         wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  bank_e         rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam bank_e ID = (b == 0) ? BANK_PING : BANK_PONG;
        logic [W-1:0] store [DEPTH];

        // store one sample when this bank is the write target
        always_ff @(posedge clk) begin
            if (wr_en && wr_bank == ID)
                store[wr_addr] <= wr_data;
        end

        assign bank_rd[b] = store[rd_addr];
    end

    // pick the read bank
    always_comb rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/afb_side_ctrl.sv
// Address and bank sequencer for one direction (fill or drain).
// Steps through DEPTH addresses and flips the active bank at the last one.
// Reports the bank just finished and keeps a sticky availability flag.
// Assumes: clear comes from the engine; a wrap in the same cycle overrides it.
module afb_side_ctrl
    import afb_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int AW        = $clog2(DEPTH),
    parameter bit INIT_FLAG = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clear,
    output logic [AW-1:0] ptr,
    output bank_e         act_bank,
    output bank_e         avail_bank,
    output logic          flag,
    output logic          wrap
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign wrap = step && (ptr == LAST);

    // position within the active bank
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= wrap ? '0 : ptr + 1'b1;
    end

    // bank flip on completion; the finished bank becomes available
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_bank   <= BANK_PING;
            avail_bank <= BANK_PONG;
        end else if (wrap) begin
            act_bank   <= (act_bank == BANK_PING) ? BANK_PONG : BANK_PING;
            avail_bank <= act_bank;
        end
    end

    // availability flag: set by completion, dropped by the engine
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= INIT_FLAG;
        else if (wrap)
            flag <= 1'b1;
        else if (clear)
            flag <= 1'b0;
    end
endmodule

// File: rtl/audio_pingpong_buf.sv
// Top level of the ping-pong audio frame buffer.
// The input stream fills one input bank while the engine reads the other.
// The output stream drains one output bank while the engine writes the other.
// Assumes: FRAME_LEN is even, so left and right samples pair up inside a bank.
module audio_pingpong_buf
    import afb_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int FRAME_LEN = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [SAMPLE_W-1:0]          in_data,
    output logic                         in_is_right,
    input  logic                         out_ready,
    output logic [SAMPLE_W-1:0]          out_data,
    output logic                         out_is_right,
    input  logic [$clog2(FRAME_LEN)-1:0] proc_addr,
    output logic [SAMPLE_W-1:0]          proc_rd_data,
    input  logic                         proc_wr_en,
    input  logic [SAMPLE_W-1:0]          proc_wr_data,
    input  logic                         proc_done,
    output logic                         frame_ready,
    output logic                         rx_full,
    output logic                         tx_empty,
    output logic                         rx_bank,
    output logic                         tx_bank,
    output logic                         overrun
);
    localparam int AW = $clog2(FRAME_LEN);

    logic [AW-1:0] rx_ptr, tx_ptr;
    bank_e         rx_fill, rx_avail, tx_drain, tx_avail;
    logic          rx_wrap, tx_wrap;
    logic          tx_wr_ok;

    afb_side_ctrl #(.DEPTH(FRAME_LEN), .AW(AW), .INIT_FLAG(1'b0)) u_rx_ctrl (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .clear(proc_done),
        .ptr(rx_ptr), .act_bank(rx_fill), .avail_bank(rx_avail),
        .flag(rx_full), .wrap(rx_wrap)
    );

    afb_side_ctrl #(.DEPTH(FRAME_LEN), .AW(AW), .INIT_FLAG(1'b1)) u_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .step(out_ready), .clear(proc_done),
        .ptr(tx_ptr), .act_bank(tx_drain), .avail_bank(tx_avail),
        .flag(tx_empty), .wrap(tx_wrap)
    );

    afb_bank_pair #(.W(SAMPLE_W), .DEPTH(FRAME_LEN), .AW(AW)) u_rx_mem (
        .clk(clk), .wr_en(in_valid), .wr_bank(rx_fill), .wr_addr(rx_ptr),
        .wr_data(in_data), .rd_bank(rx_avail), .rd_addr(proc_addr),
        .rd_data(proc_rd_data)
    );

    // engine writes land only while an output bank is on offer
    assign tx_wr_ok = proc_wr_en && tx_empty;

    afb_bank_pair #(.W(SAMPLE_W), .DEPTH(FRAME_LEN), .AW(AW)) u_tx_mem (
        .clk(clk), .wr_en(tx_wr_ok), .wr_bank(tx_avail), .wr_addr(proc_addr),
        .wr_data(proc_wr_data), .rd_bank(tx_drain), .rd_addr(tx_ptr),
        .rd_data(out_data)
    );

    // sticky overrun: unconsumed frame replaced by a newer one
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (rx_wrap && rx_full && !proc_done)
            overrun <= 1'b1;
        else if (proc_done)
            overrun <= 1'b0;
    end

    assign frame_ready  = rx_full && tx_empty;
    assign rx_bank      = rx_avail;
    assign tx_bank      = tx_avail;
    assign in_is_right  = rx_ptr[0];
    assign out_is_right = tx_ptr[0];
endmodule

// File: rtl/afb_checker.sv
// Temporal checks on the ping-pong frame buffer, bound into the top level.
// Assumes: the flag, bank and wrap signals of both direction sequencers are visible.
module afb_checker (
    input logic clk,
    input logic rst_n,
    input logic proc_done,
    input logic rx_full,
    input logic tx_empty,
    input logic overrun,
    input logic rx_bank,
    input logic tx_bank,
    input logic fill_bank,
    input logic drain_bank,
    input logic rx_wrap,
    input logic tx_wrap
);
    // R2
    rx_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_wrap));
    // R2
    rx_bank_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_bank != fill_bank));
    // R4
    tx_bank_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (tx_bank != drain_bank));
    // R4
    tx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wrap |=> (tx_empty && tx_bank == $past(drain_bank)));
    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_done && !rx_wrap) |=> !rx_full);
    // R7
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_done && !tx_wrap) |=> !tx_empty);
    // R8
    overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));
endmodule

bind audio_pingpong_buf afb_checker u_afb_checker (
    .clk(clk), .rst_n(rst_n), .proc_done(proc_done),
    .rx_full(rx_full), .tx_empty(tx_empty), .overrun(overrun),
    .rx_bank(rx_bank), .tx_bank(tx_bank),
    .fill_bank(rx_fill), .drain_bank(tx_drain),
    .rx_wrap(rx_wrap), .tx_wrap(tx_wrap)
);

// File: tb/audio_pingpong_buf_bench.sv
module audio_pingpong_buf_bench;
    localparam int N   = 256;
    localparam int LAT = 2 * N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_is_right, out_is_right;
    logic [15:0] out_data, proc_rd_data;
    logic [7:0]  proc_addr = '0;
    logic        proc_wr_en = 1'b0, proc_done = 1'b0;
    logic [15:0] proc_wr_data = '0;
    logic        frame_ready, rx_full, tx_empty, rx_bank, tx_bank, overrun;

    always #2 clk = ~clk;

    audio_pingpong_buf u_audio_pingpong_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_is_right(in_is_right), .out_ready(out_ready), .out_data(out_data),
        .out_is_right(out_is_right), .proc_addr(proc_addr),
        .proc_rd_data(proc_rd_data), .proc_wr_en(proc_wr_en),
        .proc_wr_data(proc_wr_data), .proc_done(proc_done),
        .frame_ready(frame_ready), .rx_full(rx_full), .tx_empty(tx_empty),
        .rx_bank(rx_bank), .tx_bank(tx_bank), .overrun(overrun)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    bit streaming = 1'b0;
    int in_idx = 0;
    logic [15:0] inq [$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] proc_fn(input logic [15:0] x, input int pos);
        return (pos % 2 == 0) ? (x ^ 16'h00FF) : (x + 16'd3);
    endfunction

    function automatic logic [15:0] gen(input int n);
        logic [31:0] v;
        v = n * 40503 + 17;
        return v[15:0];
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_in  [2][N];
    logic [15:0] m_out [2][N];
    bit          m_ok  [2][N];
    int m_wptr, m_rptr, m_fill, m_drain, m_rxb, m_txb;
    bit m_rx_full, m_tx_empty, m_ovr;

    always @(posedge clk) begin
        bit rw, dw;
        if (!rst_n) begin
            m_wptr = 0; m_rptr = 0; m_fill = 0; m_drain = 0;
            m_rxb = 1; m_txb = 1;
            m_rx_full = 0; m_tx_empty = 1; m_ovr = 0;
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < N; a++) m_ok[b][a] = 0;
        end else begin
            rw = in_valid && (m_wptr == N - 1);
            dw = out_ready && (m_rptr == N - 1);
            if (proc_wr_en && m_tx_empty) begin
                m_out[m_txb][proc_addr] = proc_wr_data;
                m_ok[m_txb][proc_addr]  = 1;
            end
            if (in_valid) m_in[m_fill][m_wptr] = in_data;
            if (rw && m_rx_full && !proc_done) m_ovr = 1;
            else if (proc_done) m_ovr = 0;
            if (rw) m_rx_full = 1; else if (proc_done) m_rx_full = 0;
            if (dw) m_tx_empty = 1; else if (proc_done) m_tx_empty = 0;
            if (rw) begin m_rxb = m_fill; m_fill = 1 - m_fill; end
            if (dw) begin m_txb = m_drain; m_drain = 1 - m_drain; end
            if (in_valid) m_wptr = rw ? 0 : m_wptr + 1;
            if (out_ready) m_rptr = dw ? 0 : m_rptr + 1;
        end
    end

    // compare on every clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk(rx_full == m_rx_full, "R2", "rx_full", rx_full, m_rx_full);
            chk(tx_empty == m_tx_empty, "R4", "tx_empty", tx_empty, m_tx_empty);
            chk(frame_ready == (m_rx_full && m_tx_empty), "R6", "frame_ready",
                frame_ready, m_rx_full && m_tx_empty);
            chk(rx_bank == m_rxb[0], "R2", "rx_bank", rx_bank, m_rxb);
            chk(tx_bank == m_txb[0], "R4", "tx_bank", tx_bank, m_txb);
            chk(overrun == m_ovr, "R8", "overrun", overrun, m_ovr);
            chk(in_is_right == (m_wptr % 2), "R3", "in_is_right", in_is_right, m_wptr % 2);
            chk(out_is_right == (m_rptr % 2), "R3", "out_is_right", out_is_right, m_rptr % 2);
            if (m_rx_full)
                chk(proc_rd_data == m_in[m_rxb][proc_addr], "R5", "proc_rd_data",
                    proc_rd_data, m_in[m_rxb][proc_addr]);
            if (m_ok[m_drain][m_rptr])
                chk(out_data == m_out[m_drain][m_rptr], "R4", "out_data",
                    out_data, m_out[m_drain][m_rptr]);
        end
    end

    // ---------------- stream driver: one strobe every 4 cycles ----------------
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            if (streaming && phase == 0) begin
                in_valid  = 1'b1;
                out_ready = 1'b1;
                in_data   = gen(in_idx);
                inq.push_back(in_data);
                #1;
                if (in_idx >= LAT && in_idx < LAT + 3 * N)
                    chk(out_data == proc_fn(inq[in_idx - LAT], in_idx), "R9",
                        "delayed sample", out_data, proc_fn(inq[in_idx - LAT], in_idx));
                if (in_idx == LAT + 2 * N + 5)
                    chk(out_data == proc_fn(inq[in_idx - LAT], in_idx), "R5",
                        "sample after gated write", out_data,
                        proc_fn(inq[in_idx - LAT], in_idx));
                if (in_idx == N - 1) begin
                    chk(rx_full == 1'b0, "R2", "rx_full before wrap", rx_full, 0);
                    @(posedge clk); #1;
                    chk(rx_full == 1'b1, "R2", "rx_full after wrap", rx_full, 1);
                    chk(rx_bank == 1'b0, "R2", "first full bank", rx_bank, 0);
                    chk(tx_bank == 1'b0, "R4", "first drained bank", tx_bank, 0);
                end
                in_idx++;
            end else begin
                in_valid  = 1'b0;
                out_ready = 1'b0;
            end
            phase = (phase + 1) % 4;
        end
    end

    // ---------------- engine model ----------------
    task automatic process_frame();
        do @(negedge clk); while (!frame_ready);
        for (int a = 0; a < N; a++) begin
            proc_addr = 8'(a);
            #1;
            proc_wr_data = proc_fn(proc_rd_data, a);
            proc_wr_en   = 1'b1;
            @(negedge clk);
        end
        proc_wr_en = 1'b0;
        proc_done  = 1'b1;
        @(negedge clk);
        proc_done  = 1'b0;
        chk(rx_full == 1'b0, "R7", "rx_full after done", rx_full, 0);
        chk(tx_empty == 1'b0, "R7", "tx_empty after done", tx_empty, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(rx_full == 1'b0, "R1", "reset rx_full", rx_full, 0);
        chk(tx_empty == 1'b1, "R1", "reset tx_empty", tx_empty, 1);
        chk(frame_ready == 1'b0, "R1", "reset frame_ready", frame_ready, 0);
        chk(overrun == 1'b0, "R1", "reset overrun", overrun, 0);
        chk(rx_bank == 1'b1, "R1", "reset rx_bank", rx_bank, 1);
        chk(tx_bank == 1'b1, "R1", "reset tx_bank", tx_bank, 1);
        streaming = 1'b1;

        process_frame();
        process_frame();
        process_frame();
        // write while no output bank is offered: must be dropped (R5)
        proc_addr    = 8'd5;
        proc_wr_data = 16'hDEAD;
        proc_wr_en   = 1'b1;
        @(negedge clk);
        proc_wr_en   = 1'b0;

        // skip one frame so the next input completion overruns (R8)
        wait (in_idx > 5 * N + 2);
        @(negedge clk);
        chk(overrun == 1'b1, "R8", "overrun after skipped frame", overrun, 1);
        chk(rx_bank == 1'b0, "R8", "newest frame bank", rx_bank, 0);
        process_frame();
        chk(overrun == 1'b0, "R8", "overrun cleared by done", overrun, 0);
        process_frame();
        repeat (20) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule